// File: doc/BRIEF.md
# RS485 Driver-Enable Timing Sequencer

This block controls the driver-enable line of an external half-duplex line transceiver on behalf of a UART transmitter. When the transmitter asks to send a frame, the sequencer switches the driver on first. It lets the start bit begin only after a programmable lead interval has passed. After the final stop bit of a message, it keeps the driver on for a programmable trailing interval and then releases the line.

Both intervals are counted in oversampling ticks, which arrive at sixteen per bit time on `tick_i`. Frames sent back to back keep the driver on without a break. A request that arrives while the trailing interval is running is granted at once, with no second lead interval. The active level of the enable pin can be selected. When the feature is switched off, the block is transparent: requests pass straight to the grant output and the enable pin stays inactive.

Top module: `rs485_de_seq`

## Requirements
- R1: With `en_i` low, `de_o` stays inactive, `start_o` equals `tx_req_i` in the same cycle, and `stop_done_i` has no effect on either output.
- R2: With `en_i` high and the sequencer idle, a one-cycle `tx_req_i` pulse makes `de_o` active after the next clock edge. The one-cycle `start_o` pulse follows exactly `lead_i` ticks later. A `lead_i` of 0 makes `de_o` and `start_o` appear in the same cycle.
- R3: A `stop_done_i` pulse with no request pending starts the trailing interval. `de_o` turns inactive `tail_i` ticks after the clock edge that sampled the pulse, or right after that edge when `tail_i` is 0.
- R4: A `tx_req_i` sampled in the same cycle as `stop_done_i` is granted on the next cycle. `de_o` stays active and no lead interval is inserted.
- R5: A `tx_req_i` that arrives during the trailing interval is granted on the next cycle and `de_o` stays active. The trailing interval starts again only after the next `stop_done_i`.
- R6: `pol_i` = 1 drives the active level of `de_o` high and `pol_i` = 0 drives it low. A change of `pol_i` shows on `de_o` after the next clock edge.
- R7: Only cycles with `tick_i` high advance the lead and trailing counts. Cycles with `tick_i` low stretch both intervals.
- R8: Clearing `en_i` while a frame sequence is in progress makes `de_o` inactive after the next clock edge.
- R9: With `en_i` high and the sequencer idle, a `stop_done_i` pulse changes neither output.
- R10: While enabled, `start_o` is high only while the driver is enabled. Without a `stop_done_i` in the same cycle, `start_o` is never high for two cycles in a row.
- R11: During and after reset, `de_o` is low (the active-high inactive level) and `start_o` is low while `tx_req_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Driver-enable sequencing on |
| tick_i | input | 1 | Oversampling tick, 16 per bit time |
| lead_i | input | TIME_W | Lead interval in ticks |
| tail_i | input | TIME_W | Trailing interval in ticks |
| pol_i | input | 1 | 1: enable active high, 0: active low |
| tx_req_i | input | 1 | One-cycle frame request from the transmitter |
| stop_done_i | input | 1 | One-cycle pulse at the end of a stop bit |
| de_o | output | 1 | Transceiver driver-enable pin |
| start_o | output | 1 | Permission to begin the start bit |

## Verification
The bench uses the default `TIME_W` of 5. For most sequences it holds `tick_i` high on every cycle, so that each interval equals its programmed value in clock cycles and every edge of `de_o` and `start_o` can be predicted to the exact cycle. One sequence holds `tick_i` low for several cycles during a lead interval to show that the count stretches. The intervals used range from 0 to 8, which covers the zero-delay shortcuts and the paths where a request lands inside a running trailing interval or on a stop pulse.

// File: rtl/rs485_de_pkg.sv
package rs485_de_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_LEAD   = 2'd1,
    ST_ACTIVE = 2'd2,
    ST_TAIL   = 2'd3
  } de_state_e;
endpackage

// File: rtl/rs485_guard_cnt.sv
module rs485_guard_cnt #(
  parameter int unsigned TIME_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [TIME_W-1:0] load_val_i,
  input  logic              run_i,
  input  logic              tick_i,
  output logic              expire_o
);
  localparam logic [TIME_W-1:0] ONE  = TIME_W'(1);
  localparam logic [TIME_W-1:0] ZERO = '0;

  logic [TIME_W-1:0] cnt_q;

  assign expire_o = run_i && tick_i && (cnt_q == ONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= ZERO;
    end else if (load_i) begin
      cnt_q <= load_val_i;
    end else if (run_i && tick_i && (cnt_q != ZERO)) begin
      cnt_q <= cnt_q - ONE;
    end
  end
endmodule

// File: rtl/rs485_de_fsm.sv
module rs485_de_fsm
  import rs485_de_pkg::*;
#(
  parameter int unsigned TIME_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [TIME_W-1:0] lead_i,
  input  logic [TIME_W-1:0] tail_i,
  input  logic              tx_req_i,
  input  logic              stop_done_i,
  input  logic              expire_i,
  output logic              load_o,
  output logic [TIME_W-1:0] load_val_o,
  output logic              run_o,
  output logic              grant_o,
  output logic              de_act_o
);
  localparam logic [TIME_W-1:0] ZERO = '0;

  de_state_e state_q, state_d;
  logic      pend_q, pend_d;
  logic      grant_q, grant_d;

  always_comb begin
    state_d    = state_q;
    pend_d     = pend_q;
    grant_d    = 1'b0;
    load_o     = 1'b0;
    load_val_o = lead_i;
    run_o      = 1'b0;
    if (!en_i) begin
      state_d = ST_IDLE;
      pend_d  = 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (tx_req_i) begin
            if (lead_i == ZERO) begin
              state_d = ST_ACTIVE;
              grant_d = 1'b1;
            end else begin
              state_d = ST_LEAD;
              load_o  = 1'b1;
            end
          end
        end
        ST_LEAD: begin
          run_o = 1'b1;
          if (tx_req_i) pend_d = 1'b1;
          if (expire_i) begin
            state_d = ST_ACTIVE;
            grant_d = 1'b1;
          end
        end
        ST_ACTIVE: begin
          if (stop_done_i) begin
            if (pend_q || tx_req_i) begin
              grant_d = 1'b1;
              pend_d  = pend_q && tx_req_i;
            end else if (tail_i == ZERO) begin
              state_d = ST_IDLE;
            end else begin
              state_d    = ST_TAIL;
              load_o     = 1'b1;
              load_val_o = tail_i;
            end
          end else if (tx_req_i) begin
            pend_d = 1'b1;
          end
        end
        ST_TAIL: begin
          run_o = 1'b1;
          if (tx_req_i) begin
            state_d = ST_ACTIVE;
            grant_d = 1'b1;
          end else if (expire_i) begin
            state_d = ST_IDLE;
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      pend_q  <= 1'b0;
      grant_q <= 1'b0;
    end else begin
      state_q <= state_d;
      pend_q  <= pend_d;
      grant_q <= grant_d;
    end
  end

  assign grant_o  = grant_q;
  assign de_act_o = (state_q != ST_IDLE);
endmodule

// File: rtl/rs485_de_pol.sv
module rs485_de_pol (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pol_i,
  input  logic act_i,
  output logic de_o
);
  logic pol_q;

  // polarity register resets to active-high so the pin idles low
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pol_q <= 1'b1;
    else         pol_q <= pol_i;
  end

  assign de_o = act_i ? pol_q : !pol_q;
endmodule

// File: rtl/rs485_de_seq.sv
module rs485_de_seq #(
  parameter int unsigned TIME_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              tick_i,
  input  logic [TIME_W-1:0] lead_i,
  input  logic [TIME_W-1:0] tail_i,
  input  logic              pol_i,
  input  logic              tx_req_i,
  input  logic              stop_done_i,
  output logic              de_o,
  output logic              start_o
);
  logic              cnt_load;
  logic [TIME_W-1:0] cnt_val;
  logic              cnt_run;
  logic              cnt_expire;
  logic              grant;
  logic              de_act;

  rs485_guard_cnt #(.TIME_W(TIME_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (cnt_load),
    .load_val_i (cnt_val),
    .run_i      (cnt_run),
    .tick_i     (tick_i),
    .expire_o   (cnt_expire)
  );

  rs485_de_fsm #(.TIME_W(TIME_W)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (en_i),
    .lead_i      (lead_i),
    .tail_i      (tail_i),
    .tx_req_i    (tx_req_i),
    .stop_done_i (stop_done_i),
    .expire_i    (cnt_expire),
    .load_o      (cnt_load),
    .load_val_o  (cnt_val),
    .run_o       (cnt_run),
    .grant_o     (grant),
    .de_act_o    (de_act)
  );

  rs485_de_pol u_pol (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pol_i  (pol_i),
    .act_i  (de_act),
    .de_o   (de_o)
  );

  // transparent when the feature is off
  assign start_o = en_i ? grant : tx_req_i;
endmodule

// File: rtl/rs485_de_seq_chk.sv
module rs485_de_seq_chk #(
  parameter int unsigned TIME_W = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              en_i,
  input logic              tick_i,
  input logic [TIME_W-1:0] lead_i,
  input logic [TIME_W-1:0] tail_i,
  input logic              pol_i,
  input logic              stop_done_i,
  input logic              de_o,
  input logic              start_o,
  input logic              de_act_i
);
  // R1
  disabled_inactive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (de_o == !$past(pol_i)));

  // R2
  lead_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && $past(en_i) && $rose(de_act_i) && ($past(lead_i) != '0)) |-> !start_o);

  // R3
  tail_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(en_i) && $past(de_act_i) && $past(stop_done_i) && !$past(tick_i)
     && ($past(tail_i) != '0)) |-> de_act_i);

  // R6
  idle_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && !de_act_i) |-> (de_o == !$past(pol_i)));

  // R10
  grant_de_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && start_o) |-> de_act_i);

  // R10
  grant_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && start_o && !stop_done_i) |=> (!start_o || !en_i));
endmodule

bind rs485_de_seq rs485_de_seq_chk #(.TIME_W(TIME_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .en_i        (en_i),
  .tick_i      (tick_i),
  .lead_i      (lead_i),
  .tail_i      (tail_i),
  .pol_i       (pol_i),
  .stop_done_i (stop_done_i),
  .de_o        (de_o),
  .start_o     (start_o),
  .de_act_i    (de_act)
);

// File: tb/rs485_de_seq_test.sv
module rs485_de_seq_test;
  localparam int TW = 5;
  localparam int EV_ON = 0, EV_OFF = 1, EV_GRANT = 2;

  typedef struct {
    int    kind;
    int    cyc;
    string tag;
  } ev_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          en = 1'b0, tick = 1'b1, pol = 1'b1, req = 1'b0, stop = 1'b0;
  logic [TW-1:0] lead = '0, tail = '0;
  logic          de, start;

  int  cyc = 0;
  int  checks = 0, errors = 0;
  bit  done = 1'b0;
  logic pol_ref = 1'b1;
  logic act_prev = 1'b0;
  ev_t exp_q[$];

  rs485_de_seq #(.TIME_W(TW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .tick_i(tick), .lead_i(lead),
    .tail_i(tail), .pol_i(pol), .tx_req_i(req), .stop_done_i(stop),
    .de_o(de), .start_o(start)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  // model of R6: active level follows the polarity one edge later
  always @(posedge clk or negedge rst_n) pol_ref <= !rst_n ? 1'b1 : pol;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic expect_ev(input int kind, input int at, input string tag);
    ev_t e;
    e.kind = kind; e.cyc = at; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic seen(input int kind);
    ev_t e;
    if (exp_q.size() == 0) begin
      check(1'b0, "unexpected event", kind, -1);
    end else begin
      e = exp_q.pop_front();
      check(e.kind == kind, {e.tag, " kind"}, kind, e.kind);
      check(e.cyc == cyc, {e.tag, " cycle"}, cyc, e.cyc);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic act;
      act = (de == pol_ref);
      if (act != act_prev) seen(act ? EV_ON : EV_OFF);
      if (start) seen(EV_GRANT);
      act_prev = act;
    end
  end

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic pulse_req();
    req = 1'b1; step(); req = 1'b0;
  endtask

  task automatic pulse_stop();
    stop = 1'b1; step(); stop = 1'b0;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    int c;
    step(3);
    // R11 reset state
    check(de == 1'b0, "R11 de in reset", de, 0);
    check(start == 1'b0, "R11 start in reset", start, 0);
    rst_n = 1'b1;
    step(2);
    check(de == 1'b0, "R11 de after reset", de, 0);

    // R1 transparent when disabled
    c = cyc; expect_ev(EV_GRANT, c, "R1 passthrough");
    pulse_req();
    pulse_stop();
    step(3);
    check(de == 1'b0, "R1 de stays inactive", de, 0);

    // R9 stop pulse ignored while idle and enabled
    en = 1'b1; step(2);
    pulse_stop(); step(4);
    check(de == 1'b0 && start == 1'b0, "R9 idle stop ignored", {de, start}, 0);

    // R2 lead 5, R3 tail 3
    lead = 5; tail = 3; step();
    c = cyc;
    expect_ev(EV_ON, c + 1, "R2 de on");
    expect_ev(EV_GRANT, c + 6, "R2 lead grant");
    pulse_req(); step(10);
    c = cyc; expect_ev(EV_OFF, c + 4, "R3 tail off");
    pulse_stop(); step(8);

    // R2/R3 zero intervals
    lead = 0; tail = 0; step();
    c = cyc;
    expect_ev(EV_ON, c + 1, "R2 zero lead on");
    expect_ev(EV_GRANT, c + 1, "R2 zero lead grant");
    pulse_req(); step(5);
    c = cyc; expect_ev(EV_OFF, c + 1, "R3 zero tail off");
    pulse_stop(); step(4);

    // R4 back to back
    lead = 2; tail = 4; step();
    c = cyc;
    expect_ev(EV_ON, c + 1, "R4 on");
    expect_ev(EV_GRANT, c + 3, "R4 first grant");
    pulse_req(); step(6);
    c = cyc; expect_ev(EV_GRANT, c + 1, "R4 chained grant");
    req = 1'b1; stop = 1'b1; step(); req = 1'b0; stop = 1'b0;
    step(6);
    c = cyc; expect_ev(EV_OFF, c + 5, "R4 final tail off");
    pulse_stop(); step(8);

    // R5 request inside tail
    lead = 6; tail = 8; step();
    c = cyc;
    expect_ev(EV_ON, c + 1, "R5 on");
    expect_ev(EV_GRANT, c + 7, "R5 first grant");
    pulse_req(); step(10);
    c = cyc;
    pulse_stop(); step(2);
    expect_ev(EV_GRANT, c + 4, "R5 tail grant");
    pulse_req(); step(6);
    c = cyc; expect_ev(EV_OFF, c + 9, "R5 tail restart off");
    pulse_stop(); step(12);

    // R6 polarity change while idle
    c = cyc;
    pol = 1'b0;
    check(de == 1'b0, "R6 old level kept", de, 0);
    step();
    check(de == 1'b1, "R6 new idle level", de, 1);
    lead = 3; tail = 2; step();
    c = cyc;
    expect_ev(EV_ON, c + 1, "R6 low-active on");
    expect_ev(EV_GRANT, c + 4, "R6 grant");
    pulse_req(); step(6);
    check(de == 1'b0, "R6 active low level", de, 0);
    c = cyc; expect_ev(EV_OFF, c + 3, "R6 off");
    pulse_stop(); step(5);
    check(de == 1'b1, "R6 inactive high level", de, 1);
    pol = 1'b1; step(2);

    // R7 ticks only
    lead = 2; tail = 0; tick = 1'b0; step();
    c = cyc;
    expect_ev(EV_ON, c + 1, "R7 on");
    expect_ev(EV_GRANT, c + 12, "R7 stretched grant");
    pulse_req(); step(9);
    tick = 1'b1; step(5);
    c = cyc; expect_ev(EV_OFF, c + 1, "R7 off");
    pulse_stop(); step(4);

    // R8 disable mid-sequence
    lead = 4; tail = 7; step();
    c = cyc;
    expect_ev(EV_ON, c + 1, "R8 on");
    expect_ev(EV_GRANT, c + 5, "R8 grant");
    pulse_req(); step(7);
    c = cyc; expect_ev(EV_OFF, c + 1, "R8 disable off");
    en = 1'b0; step(5);

    check(exp_q.size() == 0, "all expected events seen", exp_q.size(), 0);
    finish_run();
  end
endmodule